// File: doc/BRIEF.md
# Attributed Character Cell Renderer

This engine draws one character cell on a display controller that takes command bytes and data bytes on separate strobes. A request carries a 16-bit character word and the current X and Y cursor. The word packs a 7-bit character code with attribute bits for colour, magnification, font choice and plot-or-erase. The engine reads the foreground colour triple from an external colour table. It opens an address window on the display that covers the magnified cell. It then fetches glyph rows from an external font memory and streams three colour bytes for every displayed pixel.

Both memories are synchronous read ports: the address is driven in one cycle and the data is taken in the next. The engine accepts one request at a time and pulses a done flag when the cell is complete. The caller reads the advanced X cursor on `x_next` and uses it as the next cursor.

Top module: `chr_render`

## Requirements
- R1: A character code (word bits 6:0) below 0x20 produces no command or data write, leaves `x_next` equal to `cur_x`, and pulses `done` in the cycle after the request.
- R2: A printable character first emits command 0x2A, then four data bytes: X start high, X start low, X end high, X end low. It then emits command 0x2B with the same four bytes for Y, and then command 0x2C.
- R3: A `cur_x` of 800 or more is replaced by 0 before the window and the cursor are computed.
- R4: With magnification m = bits 13:12 + 1 and glyph width g, X end is X start + m*g - 1, Y end is Y + m*8 - 1, and `x_next` becomes X start + m*g.
- R5: Each glyph pixel is repeated m times across, and each of the 8 glyph rows is repeated m times down, giving exactly 3*(m*g)*(m*8) pixel data bytes.
- R6: Colour index c (bits 11:8) reads colour table addresses 4c, 4c+1 and 4c+2 as red, green and blue. Every pixel is sent as three data writes in red, green, blue order.
- R7: When bit 7 is 1, set glyph bits use the foreground triple. When bit 7 is 0, set glyph bits use the background triple. Clear glyph bits always use the background triple (`bg_color` = {red, green, blue}).
- R8: Font bits 15:14 = 00 select a 16-pixel-wide glyph (the whole font word) at base 0x100. Any other value selects an 8-pixel-wide glyph at base 0x600. Value 10 takes pixels from font word bits 7:0. Values 01 and 11 take pixels from bits 15:8. The row address is base + (code - 0x20)*8 + row.
- R9: Pixels in a row are emitted most significant bit first, and exactly g pixels are emitted per row.
- R10: `done` is high for exactly one cycle, in the cycle after the last blue byte.
- R11: A request raised while a cell is in progress is ignored.
- R12: During and right after reset, `cmd_we`, `dat_we` and `done` are low and `x_next` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe for one cell |
| char_word | input | 16 | Character code and attribute bits |
| cur_x | input | 16 | X cursor on entry |
| cur_y | input | 16 | Y cursor on entry |
| bg_color | input | 24 | Background triple {red, green, blue} |
| font_addr | output | 12 | Font memory read address |
| font_data | input | 16 | Font word, valid one cycle after the address |
| col_addr | output | 6 | Colour table read address |
| col_data | input | 8 | Colour byte, valid one cycle after the address |
| cmd_we | output | 1 | Command byte strobe |
| cmd_byte | output | 8 | Command byte |
| dat_we | output | 1 | Data byte strobe |
| dat_byte | output | 8 | Data byte |
| x_next | output | 16 | Advanced X cursor |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach is a second request that lands mid-cell. The bench raises it during the pixel stream, with a different word and cursor, and shows that the byte stream and the cursor still belong to the first cell. Row termination by the sentinel has to be shown for both glyph widths and for every magnification. The stimulus therefore covers all four font selections and sizes 0 to 3, and the bench checks every emitted byte against a stream that it builds from the font and colour functions. The cursor wrap is reached by starting cells at exactly 800 and above 800.

// File: rtl/chr_pkg.sv
package chr_pkg;
  localparam int GLYPH_ROWS  = 8;
  localparam int WIDE_COLS   = 16;
  localparam int NARROW_COLS = 8;
  localparam logic [7:0] OP_COLS   = 8'h2A;
  localparam logic [7:0] OP_ROWS   = 8'h2B;
  localparam logic [7:0] OP_PIXELS = 8'h2C;
  localparam logic [6:0] FIRST_PRINTABLE = 7'h20;

  typedef enum logic [2:0] {
    S_IDLE, S_CLR, S_WIN, S_FETCH, S_LOAD, S_PIX, S_FIN
  } rstate_t;

  typedef struct packed {
    logic [1:0] font;
    logic [1:0] size;
    logic [3:0] hue;
    logic       plot;
    logic [6:0] code;
  } attr_word_t;

  function automatic logic [7:0] pick3(input logic [1:0] k, input logic [23:0] t);
    case (k)
      2'd0:    pick3 = t[23:16];
      2'd1:    pick3 = t[15:8];
      default: pick3 = t[7:0];
    endcase
  endfunction
endpackage

// File: rtl/chr_window_calc.sv
module chr_window_calc
  import chr_pkg::*;
#(
  parameter int CW      = 16,
  parameter int X_LIMIT = 800
) (
  input  logic [CW-1:0] x_in,
  input  logic [CW-1:0] y_in,
  input  logic [1:0]    size,
  input  logic          wide,
  output logic [CW-1:0] xs,
  output logic [CW-1:0] xe,
  output logic [CW-1:0] ys,
  output logic [CW-1:0] ye,
  output logic [CW-1:0] xn
);
  logic [CW-1:0] mag, span_x, span_y;

  always_comb begin
    mag    = CW'(size) + CW'(1);
    span_x = mag * (wide ? CW'(WIDE_COLS) : CW'(NARROW_COLS));
    span_y = mag * CW'(GLYPH_ROWS);
    xs     = (x_in >= CW'(X_LIMIT)) ? '0 : x_in;
    xn     = xs + span_x;
    xe     = xn - CW'(1);
    ys     = y_in;
    ye     = y_in + span_y - CW'(1);
  end
endmodule

// File: rtl/chr_row_shifter.sv
module chr_row_shifter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         load,
  input  logic         step,
  input  logic         wide,
  input  logic [W-1:0] row,
  output logic         pix,
  output logic         last
);
  localparam logic [W-1:0] ONLY_MARK = {1'b1, {(W-1){1'b0}}};

  logic [W:0] sh_q, sh_d;

  always_comb begin
    sh_d = sh_q;
    if (load)
      sh_d = wide ? {row, 1'b1} : {row[W-1:W/2], 1'b1, {(W/2){1'b0}}};
    else if (step)
      sh_d = {sh_q[W-1:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sh_q <= {1'b1, {W{1'b0}}};
    else if (load || step) sh_q <= sh_d;
  end

  assign pix  = sh_q[W];
  assign last = (sh_q[W-1:0] == ONLY_MARK);

  // R9
  pixel_remains_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    step |-> (sh_q[W-1:0] != '0));
endmodule

// File: rtl/chr_render.sv
module chr_render
  import chr_pkg::*;
#(
  parameter int CW               = 16,
  parameter int FA_W             = 12,
  parameter int X_LIMIT          = 800,
  parameter int FONT_WIDE_BASE   = 'h100,
  parameter int FONT_NARROW_BASE = 'h600
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [15:0]     char_word,
  input  logic [CW-1:0]   cur_x,
  input  logic [CW-1:0]   cur_y,
  input  logic [23:0]     bg_color,
  output logic [FA_W-1:0] font_addr,
  input  logic [15:0]     font_data,
  output logic [5:0]      col_addr,
  input  logic [7:0]      col_data,
  output logic            cmd_we,
  output logic [7:0]      cmd_byte,
  output logic            dat_we,
  output logic [7:0]      dat_byte,
  output logic [CW-1:0]   x_next,
  output logic            done
);
  localparam int ROW_W = $clog2(GLYPH_ROWS);
  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(GLYPH_ROWS - 1);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ni = rs_q[1];

  rstate_t          state_q, state_d;
  attr_word_t       word_q, word_d, in_word;
  logic [CW-1:0]    xs_q, xs_d, xe_q, xe_d, ys_q, ys_d, ye_q, ye_d, x_q, x_d;
  logic [23:0]      fg_q, fg_d;
  logic [1:0]       k_q, k_d, hrep_q, hrep_d, vrep_q, vrep_d;
  logic [3:0]       win_q, win_d;
  logic [ROW_W-1:0] row_q, row_d;

  logic [CW-1:0] c_xs, c_xe, c_ys, c_ye, c_xn;
  logic          in_blank, sh_load, sh_step, sh_pix, sh_last, cur_wide;
  logic [15:0]   row_bits;
  logic [6:0]    code_off;
  logic [FA_W-1:0] font_base;

  assign in_word  = attr_word_t'(char_word);
  assign in_blank = (in_word.code < FIRST_PRINTABLE);
  assign cur_wide = (word_q.font == 2'b00);

  chr_window_calc #(.CW(CW), .X_LIMIT(X_LIMIT)) i_calc (
    .x_in(cur_x), .y_in(cur_y), .size(in_word.size),
    .wide(in_word.font == 2'b00),
    .xs(c_xs), .xe(c_xe), .ys(c_ys), .ye(c_ye), .xn(c_xn)
  );

  chr_row_shifter #(.W(16)) i_shift (
    .clk(clk), .rst_ni(rst_ni), .load(sh_load), .step(sh_step),
    .wide(cur_wide), .row(row_bits), .pix(sh_pix), .last(sh_last)
  );

  // glyph row addressing and font word selection
  assign code_off  = word_q.code - FIRST_PRINTABLE;
  assign font_base = cur_wide ? FA_W'(FONT_WIDE_BASE) : FA_W'(FONT_NARROW_BASE);
  assign font_addr = font_base + FA_W'({code_off, row_q});
  assign col_addr  = {word_q.hue, k_q};
  assign row_bits  = cur_wide               ? font_data :
                     (word_q.font == 2'b10) ? {font_data[7:0], 8'h00} :
                                              {font_data[15:8], 8'h00};
  assign x_next    = x_q;

  always_comb begin
    state_d = state_q; word_d = word_q;
    xs_d = xs_q; xe_d = xe_q; ys_d = ys_q; ye_d = ye_q; x_d = x_q;
    fg_d = fg_q; k_d = k_q; hrep_d = hrep_q; vrep_d = vrep_q;
    win_d = win_q; row_d = row_q;
    cmd_we = 1'b0; cmd_byte = 8'h00; dat_we = 1'b0; dat_byte = 8'h00;
    done = 1'b0; sh_load = 1'b0; sh_step = 1'b0;
    case (state_q)
      S_IDLE: if (start) begin
        word_d = in_word;
        xs_d = c_xs; xe_d = c_xe; ys_d = c_ys; ye_d = c_ye;
        x_d  = in_blank ? cur_x : c_xn;
        k_d  = 2'd0;
        state_d = in_blank ? S_FIN : S_CLR;
      end
      S_CLR: begin
        case (k_q)
          2'd1: fg_d[23:16] = col_data;
          2'd2: fg_d[15:8]  = col_data;
          2'd3: fg_d[7:0]   = col_data;
          default: ;
        endcase
        if (k_q == 2'd3) begin state_d = S_WIN; win_d = 4'd0; end
        else k_d = k_q + 2'd1;
      end
      S_WIN: begin
        cmd_we = (win_q == 4'd0) || (win_q == 4'd5) || (win_q == 4'd10);
        dat_we = !cmd_we;
        case (win_q)
          4'd0: cmd_byte = OP_COLS;
          4'd1: dat_byte = xs_q[15:8];
          4'd2: dat_byte = xs_q[7:0];
          4'd3: dat_byte = xe_q[15:8];
          4'd4: dat_byte = xe_q[7:0];
          4'd5: cmd_byte = OP_ROWS;
          4'd6: dat_byte = ys_q[15:8];
          4'd7: dat_byte = ys_q[7:0];
          4'd8: dat_byte = ye_q[15:8];
          4'd9: dat_byte = ye_q[7:0];
          default: cmd_byte = OP_PIXELS;
        endcase
        if (win_q == 4'd10) begin
          state_d = S_FETCH; row_d = '0; vrep_d = 2'd0;
        end else win_d = win_q + 4'd1;
      end
      S_FETCH: state_d = S_LOAD;
      S_LOAD: begin
        sh_load = 1'b1; hrep_d = 2'd0; k_d = 2'd0; state_d = S_PIX;
      end
      S_PIX: begin
        dat_we   = 1'b1;
        dat_byte = (sh_pix && word_q.plot) ? pick3(k_q, fg_q) : pick3(k_q, bg_color);
        if (k_q == 2'd2) begin
          k_d = 2'd0;
          if (hrep_q == word_q.size) begin
            hrep_d  = 2'd0;
            sh_step = 1'b1;
            if (sh_last) begin
              if (vrep_q == word_q.size) begin
                vrep_d = 2'd0;
                if (row_q == LAST_ROW) state_d = S_FIN;
                else begin row_d = row_q + 1'b1; state_d = S_FETCH; end
              end else begin
                vrep_d = vrep_q + 2'd1; state_d = S_FETCH;
              end
            end
          end else hrep_d = hrep_q + 2'd1;
        end else k_d = k_q + 2'd1;
      end
      S_FIN: begin done = 1'b1; state_d = S_IDLE; end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE; word_q <= '0;
      xs_q <= '0; xe_q <= '0; ys_q <= '0; ye_q <= '0; x_q <= '0;
      fg_q <= '0; k_q <= '0; hrep_q <= '0; vrep_q <= '0;
      win_q <= '0; row_q <= '0;
    end else begin
      state_q <= state_d; word_q <= word_d;
      xs_q <= xs_d; xe_q <= xe_d; ys_q <= ys_d; ye_q <= ye_d; x_q <= x_d;
      fg_q <= fg_d; k_q <= k_d; hrep_q <= hrep_d; vrep_q <= vrep_d;
      win_q <= win_d; row_q <= row_d;
    end
  end

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    done |=> !done);
  // R10
  last_blue_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (done && $past(dat_we)) |-> ($past(k_q) == 2'd2));
  // R11
  input_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q != S_IDLE) |=> $stable(word_q));
  // R1
  blank_done_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == S_IDLE && start && in_blank) |=> (done && !cmd_we && !dat_we));
endmodule

// File: tb/test_chr_render.sv
module test_chr_render;
  logic        clk = 1'b0;
  logic        rst_n, start;
  logic [15:0] char_word, cur_x, cur_y;
  logic [23:0] bg_color;
  logic [11:0] font_addr;
  logic [15:0] font_q;
  logic [5:0]  col_addr;
  logic [7:0]  col_q;
  logic        cmd_we, dat_we, done;
  logic [7:0]  cmd_byte, dat_byte;
  logic [15:0] x_next;

  always #4 clk = ~clk;

  chr_render i_chr_render (
    .clk(clk), .rst_n(rst_n), .start(start), .char_word(char_word),
    .cur_x(cur_x), .cur_y(cur_y), .bg_color(bg_color),
    .font_addr(font_addr), .font_data(font_q), .col_addr(col_addr),
    .col_data(col_q), .cmd_we(cmd_we), .cmd_byte(cmd_byte),
    .dat_we(dat_we), .dat_byte(dat_byte), .x_next(x_next), .done(done)
  );

  function automatic logic [15:0] font_fn(input int a);
    return 16'(a * 40503 + 4660);
  endfunction
  function automatic logic [7:0] col_fn(input int a);
    return 8'(a * 29 + 5);
  endfunction

  always @(posedge clk) begin
    font_q <= font_fn(int'(font_addr));
    col_q  <= col_fn(int'(col_addr));
  end

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, fails = 0;
  task automatic chk(input logic ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // expected stream
  bit         exp_cmd [0:8191];
  logic [7:0] exp_byte[0:8191];
  int         exp_n;

  task automatic push(input bit c, input logic [7:0] b);
    exp_cmd[exp_n] = c; exp_byte[exp_n] = b; exp_n++;
  endtask

  task automatic build_exp(input logic [15:0] w, input logic [15:0] x, input logic [15:0] y);
    int mag, gw, xs, xe, ye, base;
    logic [23:0] fg;
    logic [15:0] fw, bits;
    exp_n = 0;
    if (w[6:0] < 7'h20) return;
    mag = int'(w[13:12]) + 1;
    gw  = (w[15:14] == 2'b00) ? 16 : 8;
    base = (w[15:14] == 2'b00) ? 'h100 : 'h600;
    xs = (x >= 800) ? 0 : int'(x);
    xe = xs + mag * gw - 1;
    ye = int'(y) + mag * 8 - 1;
    fg = {col_fn(int'(w[11:8]) * 4), col_fn(int'(w[11:8]) * 4 + 1), col_fn(int'(w[11:8]) * 4 + 2)};
    push(1, 8'h2A); push(0, 8'(xs >> 8)); push(0, 8'(xs)); push(0, 8'(xe >> 8)); push(0, 8'(xe));
    push(1, 8'h2B); push(0, y[15:8]); push(0, y[7:0]); push(0, 8'(ye >> 8)); push(0, 8'(ye));
    push(1, 8'h2C);
    for (int r = 0; r < 8; r++) begin
      fw = font_fn(base + (int'(w[6:0]) - 32) * 8 + r);
      bits = (gw == 16) ? fw : (w[15:14] == 2'b10) ? {fw[7:0], 8'h00} : {fw[15:8], 8'h00};
      for (int vr = 0; vr < mag; vr++)
        for (int p = 0; p < gw; p++)
          for (int hr = 0; hr < mag; hr++)
            for (int k = 0; k < 3; k++) begin
              logic [23:0] t;
              t = (bits[15 - p] && w[7]) ? fg : bg_color;
              push(0, (k == 0) ? t[23:16] : (k == 1) ? t[15:8] : t[7:0]);
            end
    end
  endtask

  // monitor
  bit mon_on = 0;
  int obs_n, mism, mism_at, last_wr, done_cnt, done_cyc;
  always @(negedge clk) if (mon_on) begin
    if (cmd_we || dat_we) begin
      if (cmd_we && dat_we) begin
        if (mism == 0) mism_at = obs_n;
        mism++;
      end else if (obs_n >= exp_n || exp_cmd[obs_n] != cmd_we ||
                   exp_byte[obs_n] != (cmd_we ? cmd_byte : dat_byte)) begin
        if (mism == 0) mism_at = obs_n;
        mism++;
      end
      obs_n++;
      last_wr = cyc;
    end
    if (done) begin
      if (done_cnt == 0) done_cyc = cyc;
      done_cnt++;
    end
  end

  int start_cyc;
  task automatic run(input logic [15:0] w, input logic [15:0] x, input logic [15:0] y,
                     input bit inject, input logic [15:0] w2, input logic [15:0] x2);
    int n;
    build_exp(w, x, y);
    obs_n = 0; mism = 0; mism_at = -1; last_wr = -1; done_cnt = 0; done_cyc = -1;
    mon_on = 1;
    @(negedge clk);
    start = 1; char_word = w; cur_x = x; cur_y = y; start_cyc = cyc;
    @(negedge clk);
    start = 0;
    if (inject) begin
      repeat (40) @(negedge clk);
      start = 1; char_word = w2; cur_x = x2; cur_y = 16'd3;
      @(negedge clk);
      start = 0;
    end
    n = 0;
    while (done_cnt == 0 && n < 20000) begin @(negedge clk); n++; end
    if (done_cnt == 0) chk(0, "watchdog R10 no done", n, 0);
    repeat (3) @(negedge clk);
    mon_on = 0;
  endtask

  // {char_word, cur_x, cur_y, expected x_next}
  localparam logic [63:0] VEC [0:5] = '{
    {16'h0041, 16'd10,   16'd20,  16'd26},   // wide font, erase, size 0
    {16'h1FC1, 16'd100,  16'd5,   16'd132},  // wide font, plot, size 1
    {16'hB3FE, 16'd790,  16'd300, 16'd822},  // low-byte font, size 3
    {16'h65A0, 16'd800,  16'd0,   16'd24},   // high-byte font, wrap at 800, size 2
    {16'hC2DA, 16'd1000, 16'd7,   16'd8},    // high-byte font, wrap above 800
    {16'h0F9F, 16'd123,  16'd9,   16'd123}   // blank code
  };

  initial begin
    rst_n = 0; start = 0; char_word = '0; cur_x = '0; cur_y = '0;
    bg_color = 24'h102030;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(cmd_we == 0, "R12 cmd_we in reset", cmd_we, 0);
    chk(dat_we == 0, "R12 dat_we in reset", dat_we, 0);
    chk(done == 0,   "R12 done in reset", done, 0);
    chk(x_next == 0, "R12 x_next in reset", x_next, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(!cmd_we && !dat_we && !done, "R12 idle after release", {cmd_we, dat_we, done}, 0);

    for (int i = 0; i < 6; i++) begin
      logic [15:0] w, xn;
      w = VEC[i][63:48]; xn = VEC[i][15:0];
      run(w, VEC[i][47:32], VEC[i][31:16], 0, '0, '0);
      if (w[6:0] < 7'h20) begin
        chk(obs_n == 0, "R1 blank code writes nothing", obs_n, 0);
        chk(done_cyc == start_cyc + 1, "R1 done after blank request", done_cyc, start_cyc + 1);
      end else begin
        chk(mism == 0, "R2 R6 R7 R8 R9 stream mismatch index", mism_at, -1);
        chk(obs_n == exp_n, "R5 byte count", obs_n, exp_n);
        chk(done_cyc == last_wr + 1, "R10 done after last blue byte", done_cyc, last_wr + 1);
      end
      chk(x_next == xn, "R3 R4 x_next", x_next, xn);
      chk(done_cnt == 1, "R10 done width", done_cnt, 1);
    end

    // R7 erase with another background, R11 request during busy
    bg_color = 24'hA1B2C3;
    run(16'h1941, 16'd40, 16'd60, 1, 16'hB3FE, 16'd500);
    chk(mism == 0, "R11 R7 stream kept under second request", mism_at, -1);
    chk(obs_n == exp_n, "R11 byte count", obs_n, exp_n);
    chk(x_next == 16'd72, "R11 x_next of first request", x_next, 72);
    chk(done_cnt == 1, "R11 single done", done_cnt, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule